// File: doc/BRIEF.md
# Leading-One Logarithmic Bar Capture

This block turns a serial converter word into a 12-segment logarithmic level bar without doing any arithmetic. Words arrive most significant bit first, one bit for each shift strobe. A word has 16 bits: four zero bits come first, then the 12-bit sample. A sticky flag sets on the first 1 bit of the word. From then on, every bit that enters the shift register is forced to 1. When the word has been shifted in, the low twelve shift positions hold a thermometer code. That code starts at the position of the sample's leading one and fills every position below it.

An active-low latch strobe copies those twelve positions to the bar register, which drives the display segments. The same strobe clears the flag and the shift register, ready for the next word. Bit 11 of the bar is the top segment and matches the sample MSB. Each further lit segment stands for a doubling of the input, a 6.02 dB step, so the 12 segments span 72 dB. A count output gives the number of lit segments. The timing source and the LED drivers are outside this block.

Top module: `logbar_capture`

## Requirements
- R1: A synchronous active-high reset clears the bar output, the count output, the shift register and the sticky flag.
- R2: After the 16 bits of a word and a latch strobe, the bar holds the thermometer code of the sample. The bit at the sample's leading one and every lower bit are 1, and every higher bit is 0.
- R3: A sample of all zeros lights no segment: the bar is 0x000 and the count is 0.
- R4: A sample with bit 11 (the MSB) set lights all twelve segments: the bar is 0xFFF and the count is 12.
- R5: The bar output changes only on a cycle in which the latch strobe is low. Shifting in a new word leaves the displayed value unchanged.
- R6: The latch strobe clears the sticky flag and the shift register. The next word is therefore captured independently of the previous one.
- R7: The count output equals the number of lit segments. That is 12 minus the index of the leading one counted from the MSB, or 0 for an all-zero sample.
- R8: Only the low twelve shift positions reach the bar. If a 1 appears among the four leading bits, the flag sets early and the bar saturates at 0xFFF.
- R9: With the shift strobe low and the latch strobe high, the serial data line has no effect on the captured value.
- R10: When the latch strobe and the shift strobe are both active in the same cycle, the latch takes priority and the bit offered for shifting is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sdata | input | 1 | Serial word bit, MSB first |
| shift_en | input | 1 | Shift strobe; takes in one bit per high cycle |
| latch_n | input | 1 | Latch/clear strobe, active low |
| bar | output | 12 | Segment bar, bit 11 is the top segment |
| lit_count | output | 4 | Number of lit segments, 0 to 12 |

## Verification
The assertions assume that the shift register starts each word empty, because reset and every latch strobe clear it. Under that assumption its contents always have the form of zeros followed by ones, and the bar checks rely on it. The assertions also assume that a latch strobe is held low for a single cycle. The stimulus drives whole 16-bit words with one-cycle latch strobes, and directed cases probe a partial word, idle data toggling, a latch that collides with a shift, and a stray 1 among the leading bits.

// File: rtl/logbar_pkg.sv
package logbar_pkg;

    localparam int LB_WORD_BITS   = 16;
    localparam int LB_SAMPLE_BITS = 12;

    typedef enum logic [1:0] {
        LB_OP_IDLE  = 2'd0,
        LB_OP_SHIFT = 2'd1,
        LB_OP_LATCH = 2'd2
    } lb_op_e;

    // Latch beats shift when both strobes are active.
    function automatic lb_op_e lb_decode(input logic shift_en, input logic latch_n);
        if (!latch_n)
            return LB_OP_LATCH;
        else if (shift_en)
            return LB_OP_SHIFT;
        else
            return LB_OP_IDLE;
    endfunction

endpackage

// File: rtl/logbar_shifter.sv
module logbar_shifter
    import logbar_pkg::*;
#(
    parameter int WORD_BITS = LB_WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sdata,
    input  logic                 shift_en,
    input  logic                 latch_n,
    output logic [WORD_BITS-1:0] shift_word,
    output logic                 sticky
);

    typedef struct packed {
        logic [WORD_BITS-1:0] shreg;
        logic                 flag;
    } sh_state_t;

    sh_state_t st_d, st_q;
    lb_op_e    op;

    always_comb begin
        op   = lb_decode(shift_en, latch_n);
        st_d = st_q;
        unique case (op)
            LB_OP_LATCH: begin
                st_d.shreg = '0;
                st_d.flag  = 1'b0;
            end
            LB_OP_SHIFT: begin
                st_d.shreg = {st_q.shreg[WORD_BITS-2:0], sdata | st_q.flag};
                st_d.flag  = st_q.flag | sdata;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign shift_word = st_q.shreg;
    assign sticky     = st_q.flag;

    // R2: once the flag is set, every shifted bit enters as 1
    a_r2_sticky_forces_one: assert property (@(posedge clk) disable iff (rst)
        (st_q.flag && shift_en && latch_n) |=> st_q.shreg[0]);

    // R6: latch clears the flag
    a_r6_latch_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (!latch_n) |=> (!st_q.flag && st_q.shreg == '0));

    // R9: no shift strobe, no latch -> state frozen
    a_r9_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && latch_n) |=> $stable(st_q));

endmodule

// File: rtl/logbar_latch.sv
module logbar_latch
    import logbar_pkg::*;
#(
    parameter int WORD_BITS   = LB_WORD_BITS,
    parameter int SAMPLE_BITS = LB_SAMPLE_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   latch_n,
    input  logic [WORD_BITS-1:0]   shift_word,
    output logic [SAMPLE_BITS-1:0] bar_q
);

    logic [SAMPLE_BITS-1:0] bar_d;

    always_comb begin
        bar_d = bar_q;
        if (!latch_n)
            bar_d = shift_word[SAMPLE_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bar_q <= '0;
        else
            bar_q <= bar_d;
    end

    // R5: display only moves on a latch strobe
    a_r5_hold_between_latches: assert property (@(posedge clk) disable iff (rst)
        latch_n |=> $stable(bar_q));

    // R2: the bar is always a contiguous run of ones from bit 0
    a_r2_thermometer_shape: assert property (@(posedge clk) disable iff (rst)
        ((bar_q & (bar_q + SAMPLE_BITS'(1))) == '0));

endmodule

// File: rtl/logbar_count.sv
module logbar_count
    import logbar_pkg::*;
#(
    parameter int SAMPLE_BITS = LB_SAMPLE_BITS,
    localparam int CNT_W      = $clog2(SAMPLE_BITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SAMPLE_BITS-1:0] bar_q,
    output logic [CNT_W-1:0]       count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < SAMPLE_BITS; i++)
            count = count + CNT_W'(bar_q[i]);
    end

    // R7: count bounded and consistent with the end segments
    a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
        (count <= CNT_W'(SAMPLE_BITS)));
    a_r7_top_full: assert property (@(posedge clk) disable iff (rst)
        bar_q[SAMPLE_BITS-1] |-> (count == CNT_W'(SAMPLE_BITS)));
    a_r3_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (!bar_q[0]) |-> (count == '0));

endmodule

// File: rtl/logbar_capture.sv
module logbar_capture
    import logbar_pkg::*;
#(
    parameter int WORD_BITS    = LB_WORD_BITS,
    parameter int SAMPLE_BITS  = LB_SAMPLE_BITS,
    localparam int CNT_W       = $clog2(SAMPLE_BITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sdata,
    input  logic                   shift_en,
    input  logic                   latch_n,
    output logic [SAMPLE_BITS-1:0] bar,
    output logic [CNT_W-1:0]       lit_count
);

    logic [WORD_BITS-1:0] shift_word;
    logic                 sticky;

    logbar_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .sdata      (sdata),
        .shift_en   (shift_en),
        .latch_n    (latch_n),
        .shift_word (shift_word),
        .sticky     (sticky)
    );

    logbar_latch #(.WORD_BITS(WORD_BITS), .SAMPLE_BITS(SAMPLE_BITS)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .latch_n    (latch_n),
        .shift_word (shift_word),
        .bar_q      (bar)
    );

    logbar_count #(.SAMPLE_BITS(SAMPLE_BITS)) u_count (
        .clk   (clk),
        .rst   (rst),
        .bar_q (bar),
        .count (lit_count)
    );

    // R1: reset leaves an empty display
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bar == '0 && !sticky));

    // R8: a set flag at latch time means the whole low field was forced
    a_r8_sticky_low_bit: assert property (@(posedge clk) disable iff (rst)
        (sticky && latch_n) |-> shift_word[0]);

endmodule

// File: tb/sim_logbar_capture.sv
module sim_logbar_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        sdata;
    logic        shift_en;
    logic        latch_n;
    logic [11:0] bar;
    logic [3:0]  lit_count;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    logbar_capture u0 (
        .clk       (clk),
        .rst       (rst),
        .sdata     (sdata),
        .shift_en  (shift_en),
        .latch_n   (latch_n),
        .bar       (bar),
        .lit_count (lit_count)
    );

    // {sample, expected bar, expected count}
    localparam logic [27:0] VEC [12] = '{
        28'h0000000, 28'h800FFFC, 28'hFFFFFFC, 28'h0010011,
        28'h0020032, 28'h0030032, 28'h01001F5, 28'h0A50FF8,
        28'h4007FFB, 28'h1231FF9, 28'h07F07F7, 28'h5557FFB
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [3:0] lead, input logic [11:0] s);
        logic [15:0] w;
        w = {lead, s};
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            sdata    = w[i];
            shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
        sdata    = 1'b0;
        latch_n  = 1'b0;
        @(negedge clk);
        latch_n  = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sdata = 1'b0; shift_en = 1'b0; latch_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 bar after reset", bar, 12'h000);
        check("R1 count after reset", {8'h0, lit_count}, 12'h000);

        // R2 R3 R4 R7 table
        for (int k = 0; k < 12; k++) begin
            send_word(4'h0, VEC[k][27:16]);
            check("R2 bar", bar, VEC[k][15:4]);
            check("R7 count", {8'h0, lit_count}, {8'h0, VEC[k][3:0]});
        end

        // R3 explicit all-zero, R4 MSB only
        send_word(4'h0, 12'h000);
        check("R3 zero sample", bar, 12'h000);
        send_word(4'h0, 12'h800);
        check("R4 msb sample", bar, 12'hFFF);

        // R5 hold while shifting a partial word
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sdata = 1'b0; shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
        check("R5 hold mid word", bar, 12'hFFF);
        latch_n = 1'b0;
        @(negedge clk);
        latch_n = 1'b1;
        check("R5 latch partial word", bar, 12'h000);

        // R6 flag cleared between words
        send_word(4'h0, 12'h900);
        check("R6 first word", bar, 12'hFFF);
        send_word(4'h0, 12'h004);
        check("R6 second word independent", bar, 12'h007);

        // R8 stray one in leading bits
        send_word(4'h2, 12'h000);
        check("R8 lead one saturates", bar, 12'hFFF);
        check("R8 count", {8'h0, lit_count}, 12'h00C);

        // R9 data toggling without shift strobe
        send_word(4'h0, 12'h000);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sdata = ~sdata;
        end
        @(negedge clk);
        sdata = 1'b1; latch_n = 1'b0;
        @(negedge clk);
        latch_n = 1'b1; sdata = 1'b0;
        check("R9 idle data ignored", bar, 12'h000);

        // R10 latch wins over shift
        send_word(4'h0, 12'h001);
        @(negedge clk);
        sdata = 1'b1; shift_en = 1'b1; latch_n = 1'b0;
        @(negedge clk);
        sdata = 1'b0; shift_en = 1'b0; latch_n = 1'b1;
        check("R10 collide latch copies empty", bar, 12'h000);
        @(negedge clk);
        latch_n = 1'b0;
        @(negedge clk);
        latch_n = 1'b1;
        check("R10 colliding bit dropped", bar, 12'h000);

        // R1 mid-run reset
        send_word(4'h0, 12'h0F0);
        check("R1 pre-reset value", bar, 12'h0FF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears bar", bar, 12'h000);
        check("R1 reset clears count", {8'h0, lit_count}, 12'h000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule